// File: doc/BRIEF.md
# Serial Result Read-out Port for an 18-bit Sampling Converter

This block moves each finished conversion word out of the converter on a single serial data line, most significant bit first. It sits between a behavioural conversion stub, which supplies an 18-bit offset-binary word with a one-cycle completion strobe, and a host that reads the word serially. A mode input fixes the clocking. In master mode the port divides the system clock to make its own serial clock and marks each frame with a sync line. In slave mode the host supplies the serial clock and frames the transfer with an active-low chip select.

The master engine has three states. `M_IDLE` waits for a trigger. `M_LOW` and `M_HIGH` are the two halves of each serial clock period. The transitions are: idle-to-low on a trigger, low-to-high when the phase counter expires, high-to-low after each bit except the last, and high-to-idle after bit 18. The trigger is the completion strobe in read-after-convert mode and the start strobe in read-during-convert mode.

The slave engine has four states. `S_IDLE` holds while chip select is inactive. `S_SHIFT` covers the first 18 active edges. `S_CHAIN` passes the daisy-chain input through after those edges. `S_ABORT` is entered when a conversion finishes during an unfinished read. The transitions are: idle-to-shift when chip select is seen low (loading the word), shift-to-chain on the 18th active edge, shift-to-abort on a completion strobe, and any state back to idle when chip select is seen high. The host clock, chip select and daisy-chain input pass through a two-stage synchroniser. Edges are then detected in the system clock domain, so the system clock must run at least four times faster than the host clock.

Top module: `adc_serial_port`

## Requirements
- R1: In master mode with read-during-convert low, a completion strobe starts a frame in the next cycle. The frame has exactly 18 serial clock periods of 2*DIV_RAC system cycles each, and the word is presented MSB first. The data line changes only at the falling edge of the internal clock, so it is stable while the internal clock is high.
- R2: Coding select high inverts bit 17 of the stub's offset-binary word (two's complement). Coding select low sends the word unchanged. This applies in both modes.
- R3: With sync polarity low, `sync_out` is high for exactly the 36*DIV system cycles of a master frame and low otherwise. With sync polarity high, the levels are swapped.
- R4: `sclk_out` is the internal master clock XOR `sclk_inv`, so it rests at the level of `sclk_inv` whenever no frame is running.
- R5: With read-during-convert high, the start strobe begins a frame that carries the last completed result, with a period of 2*DIV_RDC cycles. In this mode a completion strobe only stores the new result and starts no frame.
- R6: A trigger that arrives while a master frame is running is ignored. The frame keeps its 18 periods and no second frame follows.
- R7: In slave mode, chip select seen low loads the current result, and `sdout` shows bit 17 of that word. Each active edge (a rising edge of `sclk_in` XOR `sclk_inv`) advances the data by one bit.
- R8: In slave mode, the `sdin` level captured at active edge k appears on `sdout` after active edge k+17. The first passed-through bit therefore follows the 18th active edge.
- R9: A completion strobe during a slave read that has seen fewer than 18 active edges raises `rd_error` for exactly one cycle, in the next cycle, and holds `sdout` at 0 until chip select goes high. A completion strobe after 18 edges raises no error.
- R10: Chip select high returns `sdout` to 0, and the next read starts again at bit 17.
- R11: A completion strobe in the same cycle in which the slave loads its word makes the load take the new result, and it raises no error.
- R12: After reset, `sdout` and `rd_error` are 0, and `sclk_out` and `sync_out` rest at their idle levels.
- R13: In slave mode the master engine is silent: triggers start no frame, `sync_out` stays inactive and `sclk_out` stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | One-cycle strobe: a conversion begins |
| conv_done | input | 1 | One-cycle strobe: conversion complete, `conv_result` valid |
| conv_result | input | DATA_W | Offset-binary result from the conversion stub |
| ext_clk_sel | input | 1 | 0 = master (internal clock), 1 = slave (host clock) |
| sclk_inv | input | 1 | Inverts the serial clock sense in both modes |
| sync_inv | input | 1 | 1 makes the master frame sync active low |
| rdc_en | input | 1 | Master read-during-convert select |
| twos_comp | input | 1 | 1 = two's complement coding, 0 = offset binary |
| sclk_in | input | 1 | Host serial clock (slave mode) |
| cs_n | input | 1 | Host chip select, active low (slave mode) |
| sdin | input | 1 | Daisy-chain serial input (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sync_out | output | 1 | Frame sync (master mode) |
| sdout | output | 1 | Serial data out |
| rd_error | output | 1 | One-cycle incomplete-read pulse (slave mode) |

## Verification
Two slave functions can fall in the same system cycle: loading the word when chip select becomes visible, and the completion strobe that replaces the stored result. The bench drives chip select low and then raises the completion strobe exactly two falling clock edges later, so that the strobe covers the load edge behind the two-stage synchroniser. It then expects the first bit and the whole shifted word to come from the new result, with `rd_error` quiet throughout. The incomplete-read strobe is provoked separately, five edges into a read, and must produce a single-cycle pulse followed by a zero data line.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        M_IDLE,
        M_LOW,
        M_HIGH
    } mst_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SHIFT,
        S_CHAIN,
        S_ABORT
    } slv_state_t;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];

endmodule

// File: rtl/adc_sp_master.sv
module adc_sp_master
    import adc_sp_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DIV_A  = 4,
    parameter int DIV_B  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              div_sel,
    input  logic [DATA_W-1:0] word,
    output logic              sclk_int,
    output logic              frame,
    output logic              sd
);

    localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int CW      = $clog2(DIV_MAX + 1);
    localparam int BW      = $clog2(DATA_W + 1);

    mst_state_t        state_q;
    logic [CW-1:0]     ph_q;
    logic [CW-1:0]     div_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              ph_end;

    assign ph_end = (ph_q == div_q - 1'b1);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_IDLE;
            ph_q    <= '0;
            div_q   <= CW'(DIV_A);
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            unique case (state_q)
                M_IDLE: begin
                    if (start) begin
                        sh_q    <= word;
                        bit_q   <= '0;
                        ph_q    <= '0;
                        div_q   <= div_sel ? CW'(DIV_B) : CW'(DIV_A);
                        state_q <= M_LOW;
                    end
                end
                M_LOW: begin
                    if (ph_end) begin
                        ph_q    <= '0;
                        state_q <= M_HIGH;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                M_HIGH: begin
                    if (ph_end) begin
                        ph_q <= '0;
                        if (bit_q == BW'(DATA_W - 1)) begin
                            state_q <= M_IDLE;
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            sh_q    <= {sh_q[DATA_W-2:0], 1'b0};
                            state_q <= M_LOW;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                default: state_q <= M_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sclk_int = (state_q == M_HIGH);
        frame    = (state_q != M_IDLE);
        sd       = frame & sh_q[DATA_W-1];
    end

endmodule

// File: rtl/adc_sp_slave.sv
module adc_sp_slave
    import adc_sp_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sclk_lv,
    input  logic              cs_act,
    input  logic              sdin_s,
    input  logic              done,
    input  logic [DATA_W-1:0] word,
    output logic              sd,
    output logic              err
);

    localparam int BW = $clog2(DATA_W + 1);

    slv_state_t        state_q;
    logic [DATA_W-1:0] sh_q;
    logic [BW-1:0]     cnt_q;
    logic              sclk_prev_q;
    logic              err_q;
    logic              act_edge;

    assign act_edge = sclk_lv & ~sclk_prev_q;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            sh_q        <= '0;
            cnt_q       <= '0;
            sclk_prev_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_lv;
            err_q       <= 1'b0;
            if (!en || !cs_act) begin
                state_q <= S_IDLE;
                cnt_q   <= '0;
                sh_q    <= '0;
            end else begin
                unique case (state_q)
                    S_IDLE: begin
                        sh_q    <= word;
                        cnt_q   <= '0;
                        state_q <= S_SHIFT;
                    end
                    S_SHIFT: begin
                        if (done) begin
                            err_q   <= 1'b1;
                            sh_q    <= '0;
                            state_q <= S_ABORT;
                        end else if (act_edge) begin
                            sh_q  <= {sh_q[DATA_W-2:0], sdin_s};
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == BW'(DATA_W - 1)) state_q <= S_CHAIN;
                        end
                    end
                    S_CHAIN: begin
                        if (act_edge) sh_q <= {sh_q[DATA_W-2:0], sdin_s};
                    end
                    S_ABORT: state_q <= S_ABORT;
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sd  = ((state_q == S_SHIFT) || (state_q == S_CHAIN)) & sh_q[DATA_W-1];
        err = err_q;
    end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
    parameter int DATA_W      = 18,
    parameter int DIV_RAC     = 4,
    parameter int DIV_RDC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              ext_clk_sel,
    input  logic              sclk_inv,
    input  logic              sync_inv,
    input  logic              rdc_en,
    input  logic              twos_comp,
    input  logic              sclk_in,
    input  logic              cs_n,
    input  logic              sdin,
    output logic              sclk_out,
    output logic              sync_out,
    output logic              sdout,
    output logic              rd_error
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] last_q;
    logic [DATA_W-1:0] fresh_coded;
    logic [DATA_W-1:0] prev_coded;
    logic              m_start;
    logic              m_sclk, m_frame, m_sd;
    logic [2:0]        sync_q;
    logic              s_sd, s_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         last_q <= '0;
        else if (conv_done) last_q <= conv_result;
    end

    assign fresh_coded = {conv_result[MSB] ^ twos_comp, conv_result[MSB-1:0]};
    assign prev_coded  = {last_q[MSB] ^ twos_comp, last_q[MSB-1:0]};
    assign m_start     = ~ext_clk_sel & (rdc_en ? conv_start : conv_done);

    adc_sp_master #(
        .DATA_W (DATA_W),
        .DIV_A  (DIV_RAC),
        .DIV_B  (DIV_RDC)
    ) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (m_start),
        .div_sel  (rdc_en),
        .word     (rdc_en ? prev_coded : fresh_coded),
        .sclk_int (m_sclk),
        .frame    (m_frame),
        .sd       (m_sd)
    );

    adc_sp_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, cs_n, sdin}),
        .q     (sync_q)
    );

    adc_sp_slave #(
        .DATA_W (DATA_W)
    ) u_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ext_clk_sel),
        .sclk_lv (sync_q[2] ^ sclk_inv),
        .cs_act  (~sync_q[1]),
        .sdin_s  (sync_q[0]),
        .done    (conv_done),
        .word    (conv_done ? fresh_coded : prev_coded),
        .sd      (s_sd),
        .err     (s_err)
    );

    always_comb begin
        sdout    = ext_clk_sel ? s_sd : m_sd;
        sclk_out = (~ext_clk_sel & m_sclk) ^ sclk_inv;
        sync_out = (~ext_clk_sel & m_frame) ^ sync_inv;
        rd_error = s_err;
    end

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
    parameter int DATA_W  = 18,
    parameter int DIV_RAC = 4,
    parameter int DIV_RDC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ext_clk_sel,
    input logic sclk_inv,
    input logic sync_inv,
    input logic cs_n,
    input logic sclk_out,
    input logic sync_out,
    input logic sdout,
    input logic rd_error
);

    localparam int DIV_MAX = (DIV_RAC > DIV_RDC) ? DIV_RAC : DIV_RDC;
    localparam int LIMIT   = 2 * DIV_MAX * DATA_W;
    localparam int CNT_W   = $clog2(LIMIT + 2);

    logic [CNT_W-1:0] frame_cnt;
    logic [1:0]       cs_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            cs_hi_cnt <= '0;
        end else begin
            if (sync_out != sync_inv) frame_cnt <= frame_cnt + 1'b1;
            else                      frame_cnt <= '0;
            if (!cs_n)                  cs_hi_cnt <= '0;
            else if (cs_hi_cnt != 2'd3) cs_hi_cnt <= cs_hi_cnt + 1'b1;
        end
    end

    // R9
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_error |=> !rd_error);

    // R13
    no_master_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk_sel && $past(!ext_clk_sel)) |-> !rd_error);

    // R13
    sync_master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out != sync_inv) |-> !ext_clk_sel);

    // R4
    sclk_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk_sel && (sync_out == sync_inv)) |-> (sclk_out == sclk_inv));

    // R1
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk_sel && $past(!ext_clk_sel) && (sclk_out != sclk_inv)) |-> $stable(sdout));

    // R3
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CNT_W'(LIMIT));

    // R10
    cs_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clk_sel && cs_hi_cnt == 2'd3) |-> !sdout);

endmodule

bind adc_serial_port adc_serial_port_chk #(
    .DATA_W  (DATA_W),
    .DIV_RAC (DIV_RAC),
    .DIV_RDC (DIV_RDC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_clk_sel (ext_clk_sel),
    .sclk_inv    (sclk_inv),
    .sync_inv    (sync_inv),
    .cs_n        (cs_n),
    .sclk_out    (sclk_out),
    .sync_out    (sync_out),
    .sdout       (sdout),
    .rd_error    (rd_error)
);

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;

    localparam int DW   = 18;
    localparam int DIVA = 4;
    localparam int DIVB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0, conv_done = 1'b0;
    logic [DW-1:0] conv_result = '0;
    logic ext_clk_sel = 1'b0, sclk_inv = 1'b0, sync_inv = 1'b0;
    logic rdc_en = 1'b0, twos_comp = 1'b0;
    logic sclk_in = 1'b0, cs_n = 1'b1, sdin = 1'b0;
    logic sclk_out, sync_out, sdout, rd_error;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    adc_serial_port #(
        .DATA_W (DW), .DIV_RAC (DIVA), .DIV_RDC (DIVB), .SYNC_STAGES (2)
    ) i_adc_serial_port (
        .clk (clk), .rst_n (rst_n), .conv_start (conv_start), .conv_done (conv_done),
        .conv_result (conv_result), .ext_clk_sel (ext_clk_sel), .sclk_inv (sclk_inv),
        .sync_inv (sync_inv), .rdc_en (rdc_en), .twos_comp (twos_comp),
        .sclk_in (sclk_in), .cs_n (cs_n), .sdin (sdin),
        .sclk_out (sclk_out), .sync_out (sync_out), .sdout (sdout), .rd_error (rd_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // master frame: trigger, then observe sclk/sync/sdout at falling clock edges
    task automatic run_master(input bit use_rdc, input logic [DW-1:0] exp_w,
                              input int div, input int inj_kind, input int inj_at,
                              input string tag);
        logic [DW-1:0] got = '0;
        int rises = 0, act = 0, last = -1, bad = 0;
        logic prev = 1'b0;
        @(negedge clk);
        if (use_rdc) conv_start = 1'b1; else conv_done = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        conv_done  = 1'b0;
        for (int cyc = 0; cyc < 38 * div + 20; cyc++) begin
            logic s;
            s = sclk_out ^ sclk_inv;
            if (sync_out ^ sync_inv) act++;
            if (s && !prev) begin
                rises++;
                got = {got[DW-2:0], sdout};
                if (last >= 0 && (cyc - last) != 2 * div) bad++;
                last = cyc;
            end
            prev = s;
            conv_done  = (inj_kind == 1) && (cyc == inj_at);
            conv_start = (inj_kind == 2) && (cyc == inj_at);
            @(negedge clk);
        end
        conv_done  = 1'b0;
        conv_start = 1'b0;
        check({tag, " R1 period count"}, rises, 18);
        check({tag, " R1 word"}, got, exp_w);
        check({tag, " R3 sync length"}, act, 36 * div);
        check({tag, " R1 period length errors"}, bad, 0);
    endtask

    function automatic logic exp_bit(input logic [DW-1:0] w, input int i, input logic [7:0] pat);
        if (i < DW) return w[DW-1-i];
        return pat[(i - DW) % 8];
    endfunction

    task automatic shift_bits(input logic [DW-1:0] w, input int nbits,
                              input logic [7:0] pat, input string tag);
        for (int i = 0; i < nbits; i++) begin
            check({tag, (i < DW) ? " R7 bit" : " R8 chain bit"}, sdout, exp_bit(w, i, pat));
            sclk_in = ~sclk_inv;
            sdin    = pat[i % 8];
            repeat (8) @(negedge clk);
            sclk_in = sclk_inv;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic run_slave(input logic [DW-1:0] w, input int nbits,
                             input logic [7:0] pat, input string tag);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        shift_bits(w, nbits, pat, tag);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check({tag, " R10 idle after cs"}, sdout, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R12 sdout", sdout, 0);
        check("R12 rd_error", rd_error, 0);
        check("R12 sclk_out", sclk_out, 0);
        check("R12 sync_out", sync_out, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_master_plain();
        conv_result = 18'h2A5C3;
        run_master(1'b0, 18'h2A5C3, DIVA, 0, 0, "rac");
    endtask

    task automatic t_master_inverted();
        @(negedge clk);
        sclk_inv = 1'b1; sync_inv = 1'b1; twos_comp = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 idle sclk inverted", sclk_out, 1);
        check("R3 idle sync inverted", sync_out, 1);
        conv_result = 18'h15A3C;
        // retrigger at cycle 20 must be ignored (R6), coding flips bit 17 (R2)
        run_master(1'b0, 18'h15A3C ^ 18'h20000, DIVA, 1, 20, "inv R2 R6");
        sclk_inv = 1'b0; sync_inv = 1'b0; twos_comp = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_master_rdc();
        int act = 0;
        rdc_en = 1'b1;
        conv_result = 18'h0F0F1;
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        for (int c = 0; c < 30; c++) begin
            if (sync_out ^ sync_inv) act++;
            @(negedge clk);
        end
        check("R5 done starts no frame", act, 0);
        conv_result = 18'h3C3A5;
        run_master(1'b1, 18'h0F0F1, DIVB, 1, 10, "rdc R5 prev");
        run_master(1'b1, 18'h3C3A5, DIVB, 0, 0, "rdc R5 next");
        rdc_en = 1'b0;
    endtask

    task automatic t_slave_chain();
        int errs = 0;
        ext_clk_sel = 1'b1;
        conv_result = 18'h2B6D9;
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        repeat (8) @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        shift_bits(18'h2B6D9, DW + 8, 8'b1011_0010, "slave");
        conv_result = 18'h1D2E7;
        conv_done = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            conv_done = 1'b0;
            if (rd_error) errs++;
        end
        check("R9 no error after full read", errs, 0);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R10 idle after chain", sdout, 0);
    endtask

    task automatic t_slave_inverted();
        @(negedge clk);
        sclk_inv = 1'b1; sclk_in = 1'b1; twos_comp = 1'b1;
        repeat (10) @(negedge clk);
        run_slave(18'h1D2E7 ^ 18'h20000, DW, 8'h00, "slave inv R2");
        sclk_inv = 1'b0; sclk_in = 1'b0; twos_comp = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_slave_abort();
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        shift_bits(18'h1D2E7, 5, 8'h00, "abort pre");
        conv_result = 18'h0A5F0;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        check("R9 error pulse", rd_error, 1);
        @(negedge clk);
        check("R9 error one cycle", rd_error, 0);
        sclk_in = 1'b1; repeat (8) @(negedge clk);
        sclk_in = 1'b0; repeat (8) @(negedge clk);
        check("R9 data held zero", sdout, 0);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        run_slave(18'h0A5F0, DW, 8'h00, "after abort R10");
    endtask

    task automatic t_coincide();
        int errs = 0;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk); conv_result = 18'h36C91; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (rd_error) errs++;
            @(negedge clk);
        end
        check("R11 no error on coincident load", errs, 0);
        shift_bits(18'h36C91, DW, 8'h00, "coincide R11");
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_slave_quiet_master();
        int bad = 0;
        conv_result = 18'h11111;
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        for (int c = 0; c < 60; c++) begin
            if (sync_out !== sync_inv || sclk_out !== sclk_inv) bad++;
            @(negedge clk);
        end
        check("R13 master silent in slave mode", bad, 0);
        ext_clk_sel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("  Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_master_plain();
        t_master_inverted();
        t_master_rdc();
        t_slave_chain();
        t_slave_inverted();
        t_slave_abort();
        t_coincide();
        t_slave_quiet_master();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule